// File: doc/BRIEF.md
# Universal Latch/Register Bus Driver

This block is an 18-bit data path stage placed between an input bus A and an output bus Y. One storage element changes behaviour with a latch-enable input. While latch-enable is high, the storage is transparent and Y follows A with no clock involved. While latch-enable is low, the storage loads A on each rising clock edge and holds it between edges.

An active-low output enable works separately from the storage. It either drives Y from the stored or passed-through value, or releases every Y bit to high impedance. A drive-enable vector is provided next to Y. It carries the same per-bit enable that the tri-state drivers use, so an FPGA flow can map Y onto I/O buffers and a simulator can observe the high-impedance state.

A synchronous active-high reset clears the stored value. It takes effect on a rising clock edge while the storage is in its clocked mode.

Top module: `univ_bus_driver`

## Requirements
- R1: While `le` is high, the internal value equals `a` continuously. With `oe_n` low, `y` equals `a` bit for bit, with no clock edge needed.
- R2: While `le` is low, each rising edge of `clk` loads `a` into storage. With `oe_n` low, `y` shows the loaded value right after that edge.
- R3: While `le` is low and `clk` holds steady, changes on `a` leave `y` unchanged.
- R4: When `le` falls from high to low, storage keeps the value that `a` had at the moment of the fall, until the next rising `clk` edge.
- R5: A rising `clk` edge while `le` is high has no effect beyond transparency. `y` still equals `a` after the edge and keeps tracking later changes of `a`.
- R6: With `oe_n` high, every bit of `drv_en` is 0 and `y` is high impedance. With `oe_n` low, every bit of `drv_en` is 1 and `y` is driven.
- R7: Storage keeps capturing and passing through while `oe_n` is high. The value it holds appears on `y` as soon as `oe_n` goes low.
- R8: A rising `clk` edge with `rst` high and `le` low clears the stored value to all zeros. While `le` is high, `rst` does not change `y`.

Verification guidance: the reset in R8 has no counterpart in the plain latch/register behaviour and should be treated as a project addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active in clocked mode |
| rst | input | 1 | Synchronous active-high clear of storage in clocked mode |
| le | input | 1 | High: transparent; low: edge-triggered storage |
| oe_n | input | 1 | Active-low output enable |
| a | input | 18 | Input data bus |
| y | output | 18 | Tri-state output data bus |
| drv_en | output | 18 | Per-bit drive enable for the output buffers |

## Verification
Two events can land in the same clock period: latch-enable falling and a clock edge capturing. The bench provokes this by raising and lowering `le` between two rising edges while `a` changes in every phase. Each step is judged against a bench model. The model freezes on the last transparent value at the fall and takes the new `a` at the following edge.

Output enable is also toggled in the same periods as captures and transparent updates. The bench confirms that the value held while the outputs were released appears on `y` once they are enabled again.

// File: rtl/ubd_pkg.sv
package ubd_pkg;
  localparam int unsigned UBD_WIDTH = 18;

  // fan one enable bit out across a bus of the given width
  function automatic logic [UBD_WIDTH-1:0] fan_out(input logic bit_in);
    return {UBD_WIDTH{bit_in}};
  endfunction
endpackage

// File: rtl/ubd_store.sv
// Single logical storage element: transparent latch while le is high,
// rising-edge register while le is low. A freshness flag, cleared
// asynchronously by le, tells whether the last update came from the
// transparent path or from a clock edge.
module ubd_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] core
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] reg_q;
  logic             edge_newer;

  always_latch begin
    if (le) lat_q <= a;
  end

  always_ff @(posedge clk) begin
    if (!le) reg_q <= rst ? '0 : a;
  end

  always_ff @(posedge clk or posedge le) begin
    if (le) edge_newer <= 1'b0;
    else    edge_newer <= 1'b1;
  end

  always_comb begin
    if (le)              core = a;
    else if (edge_newer) core = reg_q;
    else                 core = lat_q;
  end
endmodule

// File: rtl/ubd_outbuf.sv
// Per-bit tri-state output stage with an exported enable vector.
module ubd_outbuf #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] d,
  output wire  [WIDTH-1:0] y,
  output logic [WIDTH-1:0] drv_en
);
  assign drv_en = {WIDTH{~oe_n}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = drv_en[i] ? d[i] : 1'bz;
  end
endmodule

// File: rtl/univ_bus_driver.sv
module univ_bus_driver #(
  parameter int unsigned WIDTH = ubd_pkg::UBD_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] a,
  output wire  [WIDTH-1:0] y,
  output logic [WIDTH-1:0] drv_en
);
  logic [WIDTH-1:0] core_q;

  ubd_store #(.WIDTH(WIDTH)) u_store (
    .clk  (clk),
    .rst  (rst),
    .le   (le),
    .a    (a),
    .core (core_q)
  );

  ubd_outbuf #(.WIDTH(WIDTH)) u_out (
    .oe_n   (oe_n),
    .d      (core_q),
    .y      (y),
    .drv_en (drv_en)
  );
endmodule

// File: rtl/univ_bus_driver_chk.sv
module univ_bus_driver_chk #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             le,
  input logic             oe_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] core,
  input logic [WIDTH-1:0] drv_en
);
  a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
    le |-> core == a);

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> drv_en == '0);

  a_r6_drive: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> &drv_en);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(!le) && !le) |-> core == '0);
endmodule

bind univ_bus_driver univ_bus_driver_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .le     (le),
  .oe_n   (oe_n),
  .a      (a),
  .core   (core_q),
  .drv_en (drv_en)
);

// File: tb/tb_univ_bus_driver.sv
module tb_univ_bus_driver;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         le = 1'b0;
  logic         oe_n = 1'b0;
  logic [W-1:0] a = '0;
  wire  [W-1:0] y;
  logic [W-1:0] drv_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] model;

  univ_bus_driver #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .le(le), .oe_n(oe_n), .a(a), .y(y), .drv_en(drv_en)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] pat(input int k);
    logic [31:0] v;
    v = (k * 32'h9E3779B1) ^ (k << 7) ^ 32'h0001_5A3C;
    return v[W-1:0];
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait to 2 ns after the next rising edge
  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    // R8: reset state in clocked mode
    after_edge();
    after_edge();
    chk("R8 reset clears", y, '0);
    chk("R6 enabled drv_en", drv_en, '1);
    rst = 1'b0;
    after_edge();
    chk("R8 held after reset", y, '0);

    // R1: transparent sweep, no clock involvement
    le = 1'b1;
    for (int k = 0; k < 24; k++) begin
      a = pat(k);
      #1;
      chk("R1 transparent", y, pat(k));
    end

    // R5: edge while transparent
    a = pat(100);
    after_edge();
    chk("R5 edge in transparent", y, pat(100));
    a = pat(101);
    #1;
    chk("R5 tracks after edge", y, pat(101));

    // R4: le falls mid-cycle, value frozen until next edge
    le = 1'b0;
    #1;
    a = pat(102);
    #1;
    chk("R4 hold after fall", y, pat(101));
    after_edge();
    chk("R2 capture after fall", y, pat(102));

    // R2/R3 sweep in clocked mode
    for (int k = 0; k < 20; k++) begin
      a = pat(200 + k);
      after_edge();
      chk("R2 capture", y, pat(200 + k));
      a = ~pat(200 + k);
      #1;
      chk("R3 static clock hold", y, pat(200 + k));
    end

    // LE pulse inside one period
    a = pat(300);
    after_edge();
    le = 1'b1;
    #1;
    a = pat(301);
    #1;
    chk("R1 pulse open", y, pat(301));
    le = 1'b0;
    #1;
    a = pat(302);
    #1;
    chk("R4 pulse close", y, pat(301));
    after_edge();
    chk("R2 after pulse", y, pat(302));

    // R6 / R7: storage active while released
    oe_n = 1'b1;
    #1;
    chk("R6 released drv_en", drv_en, '0);
    a = pat(400);
    after_edge();
    chk("R6 released after capture", drv_en, '0);
    oe_n = 1'b0;
    #1;
    chk("R7 captured while released", y, pat(400));
    oe_n = 1'b1;
    le = 1'b1;
    #1;
    a = pat(401);
    #1;
    oe_n = 1'b0;
    #1;
    chk("R7 passed while released", y, pat(401));
    chk("R6 drive on", drv_en, '1);

    // R8: reset ignored while transparent, clears in clocked mode
    rst = 1'b1;
    after_edge();
    chk("R8 no effect when transparent", y, pat(401));
    le = 1'b0;
    after_edge();
    chk("R8 clear in clocked mode", y, '0);
    rst = 1'b0;
    after_edge();

    // near-exhaustive sweep over le/oe_n combinations against a model
    model = y;
    for (int k = 0; k < 64; k++) begin
      le = k[0];
      oe_n = k[1];
      if (le) model = a;
      #1;
      a = pat(500 + k);
      if (le) model = a;
      #1;
      if (oe_n) chk("R6 sweep released", drv_en, '0);
      else      chk("R1/R3 sweep mid", y, model);
      @(posedge clk);
      if (!le) model = a;
      #1;
      if (oe_n) chk("R6 sweep released", drv_en, '0);
      else      chk("R2/R5 sweep edge", y, model);
      #1;
    end

    done = 1'b1;
    summary();
  end
endmodule